// File: doc/BRIEF.md
# Crystal-Referenced Motor Speed Discriminator

This block compares the speed of a motor's tachometer signal with a crystal time base and produces two things: a correction pulse for a charge-pump integrator and a lock flag. The reference clock goes through a divide-by-16 prescaler. Each period of the tachometer signal is timed in prescaler ticks. When the speed is exactly on target, a period lasts 512 ticks, so the target tachometer frequency is the reference clock divided by 8192.

Periods alternate between two roles. In a measuring period the block times the interval. In the period that follows, it drives the resulting error onto one of two pump outputs. An overspeed error (a period shorter than nominal) raises the up output. An underspeed error raises the down output. The length of the pulse, in ticks, is the distance between the measured count and 512. While either output is active, a tri-state enable tells the analog pump stage to conduct. The active-low lock flag goes low when the measured count lies within ±6.25 % of nominal.

A start control puts the block in a stopped state. While stopped, only the prescaler keeps running. The measurement is held idle, both pump outputs and the enable are off, the lock flag is released, and tachometer edges are ignored.

Top module: `speed_discrim`

## Requirements
- R1: The prescaler produces one tick every 16 reference clocks. The measured count of a period equals the number of ticks between two successive tachometer rising edges, so edges spaced 16·N clocks apart measure exactly N.
- R2: After reset or a restart, the first tachometer rising edge only arms the measurement. From then on, rising edges alternate between "capture the period just measured" and "start a new measurement", so one error is issued every two tachometer periods.
- R3: A captured count below 512 gives a pulse on the overspeed output `ovr_up`. It lasts (512 − count) ticks, which is 16·(512 − count) reference clocks, and it starts on a tick after the capture.
- R4: A captured count above 512 gives a pulse on the underspeed output `udr_dn` lasting (count − 512) ticks.
- R5: A captured count of exactly 512 produces no pulse on either output.
- R6: The pulse length saturates at 511 ticks. The period counter saturates at 1023, so a very slow motor gives a 511-tick underspeed pulse and a near-zero period gives a 511-tick overspeed pulse.
- R7: `lock_n` is driven low when the captured count lies in 480..544 inclusive, and high otherwise. It changes only when a period is captured.
- R8: `pump_oe` is high exactly while one of the two pump outputs is high, and the two pump outputs are never high together.
- R9: While `run_en` is low, both pump outputs and `pump_oe` go low and `lock_n` goes high within one clock, and tachometer edges have no effect.
- R10: During and right after reset, `lock_n` is high and no pump output is active, so lock is never falsely reported at power-up.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Crystal reference clock |
| rst_n | input | 1 | Synchronous reset, active low |
| run_en | input | 1 | High to run, low to stop |
| fg_in | input | 1 | Tachometer pulse, asynchronous |
| ovr_up | output | 1 | Overspeed correction pulse |
| udr_dn | output | 1 | Underspeed correction pulse |
| pump_oe | output | 1 | Charge-pump output enable |
| lock_n | output | 1 | Low when speed is within the lock window |

## Verification
The bench times tachometer edges in exact multiples of 16 clocks and measures every pump pulse to the clock. This exposes an off-by-one in the edge-to-tick window, which would stretch or shrink each pulse by 16 clocks. It also targets the lock window edges at 479, 480, 544 and 545, where a wrong comparison flips `lock_n`. It drives both saturation extremes (counts 1 and beyond 1023), where a missing clamp would wrap the counter or the pulse length. Last, it stops the block in the middle of a pulse and restarts it after an idle gap. A design that did not arm on the first edge after restart would capture that gap as a period and emit a bogus overspeed pulse.

// File: rtl/sd_pkg.sv
// Shared types for the speed discriminator.
// Assumes: used only by modules of this block.
package sd_pkg;

    // role of the current tachometer period
    typedef enum logic {
        PH_MEASURE = 1'b0,
        PH_OUTPUT  = 1'b1
    } sd_phase_e;

    // direction of a pending or active correction pulse
    typedef enum logic [1:0] {
        DIR_NONE = 2'd0,
        DIR_UP   = 2'd1,
        DIR_DN   = 2'd2
    } sd_dir_e;

endpackage

// File: rtl/sd_prescaler.sv
// Divides the reference clock into a one-cycle tick every DIV clocks.
// Assumes: it keeps running whatever the run state is; only reset clears it.
module sd_prescaler #(
    parameter int DIV = 16
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    localparam int PW = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [PW-1:0] LAST = PW'(DIV - 1);

    generate
        if (DIV == 1) begin : g_bypass
            assign tick = 1'b1;
        end else begin : g_count
            logic [PW-1:0] div_q;

            // free-running modulo-DIV counter
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    div_q <= '0;
                end else if (div_q == LAST) begin
                    div_q <= '0;
                end else begin
                    div_q <= div_q + 1'b1;
                end
            end

            assign tick = (div_q == LAST);
        end
    endgenerate
endmodule

// File: rtl/sd_fg_sync.sv
// Brings the asynchronous tachometer input into the clock domain and
// flags each rising edge for one cycle.
// Assumes: tachometer high and low phases each last at least two clocks.
module sd_fg_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic fg_in,
    output logic fg_rise
);
    logic [STAGES-1:0] sync_q;
    logic              last_q;

    genvar gi;
    generate
        for (gi = 0; gi < STAGES; gi++) begin : g_stage
            if (gi == 0) begin : g_first
                // first capture flop of the synchronizer
                always_ff @(posedge clk) begin
                    if (!rst_n) sync_q[0] <= 1'b0;
                    else        sync_q[0] <= fg_in;
                end
            end else begin : g_next
                // further synchronizer stages
                always_ff @(posedge clk) begin
                    if (!rst_n) sync_q[gi] <= 1'b0;
                    else        sync_q[gi] <= sync_q[gi-1];
                end
            end
        end
    endgenerate

    // delayed copy for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) last_q <= 1'b0;
        else        last_q <= sync_q[STAGES-1];
    end

    assign fg_rise = sync_q[STAGES-1] & ~last_q;
endmodule

// File: rtl/sd_period_meter.sv
// Counts prescaler ticks between tachometer rising edges and captures the
// count on every second edge. The first edge after start only arms.
// Assumes: fg_rise and tick are single-cycle strobes.
module sd_period_meter
    import sd_pkg::*;
#(
    parameter int CNT_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_en,
    input  logic             tick,
    input  logic             fg_rise,
    output logic             cap_valid,
    output logic [CNT_W-1:0] cap_count
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    logic             armed_q;
    sd_phase_e        phase_q;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] cnt_inc;

    // count including a tick that lands in the current cycle, saturating
    always_comb begin
        if (tick && (cnt_q != CNT_MAX)) cnt_inc = cnt_q + 1'b1;
        else                            cnt_inc = cnt_q;
    end

    // arming, phase alternation, tick counting and capture
    always_ff @(posedge clk) begin
        if (!rst_n || !run_en) begin
            armed_q   <= 1'b0;
            phase_q   <= PH_MEASURE;
            cnt_q     <= '0;
            cap_valid <= 1'b0;
            cap_count <= '0;
        end else begin
            cap_valid <= 1'b0;
            if (fg_rise) begin
                cnt_q <= '0;
                if (!armed_q) begin
                    armed_q <= 1'b1;
                    phase_q <= PH_MEASURE;
                end else if (phase_q == PH_MEASURE) begin
                    cap_count <= cnt_inc;
                    cap_valid <= 1'b1;
                    phase_q   <= PH_OUTPUT;
                end else begin
                    phase_q <= PH_MEASURE;
                end
            end else begin
                cnt_q <= cnt_inc;
            end
        end
    end
endmodule

// File: rtl/sd_err_pulse.sv
// Turns a captured period count into an up or down pulse whose length in
// ticks is the distance from nominal, clamped. The pulse starts on a tick
// so that its length is a whole number of ticks.
// Assumes: a new capture arrives only after the previous pulse has ended.
module sd_err_pulse
    import sd_pkg::*;
#(
    parameter int CNT_W   = 10,
    parameter int NOMINAL = 512,
    parameter int ERR_MAX = 511
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_en,
    input  logic             tick,
    input  logic             cap_valid,
    input  logic [CNT_W-1:0] cap_count,
    output logic             pulse_up,
    output logic             pulse_dn
);
    localparam logic [CNT_W-1:0] NOM_C = CNT_W'(NOMINAL);
    localparam logic [CNT_W-1:0] MAX_C = CNT_W'(ERR_MAX);

    logic [CNT_W-1:0] raw_mag;
    logic [CNT_W-1:0] sat_mag;
    sd_dir_e          raw_dir;

    logic             pend_q;
    logic [CNT_W-1:0] pend_mag_q;
    sd_dir_e          pend_dir_q;
    logic [CNT_W-1:0] remain_q;
    sd_dir_e          dir_q;

    // signed distance from nominal split into direction and magnitude
    always_comb begin
        if (cap_count < NOM_C) begin
            raw_mag = NOM_C - cap_count;
            raw_dir = DIR_UP;
        end else if (cap_count > NOM_C) begin
            raw_mag = cap_count - NOM_C;
            raw_dir = DIR_DN;
        end else begin
            raw_mag = '0;
            raw_dir = DIR_NONE;
        end
        sat_mag = (raw_mag > MAX_C) ? MAX_C : raw_mag;
    end

    // hold a fresh error until the next tick boundary
    always_ff @(posedge clk) begin
        if (!rst_n || !run_en) begin
            pend_q     <= 1'b0;
            pend_mag_q <= '0;
            pend_dir_q <= DIR_NONE;
        end else if (cap_valid) begin
            pend_q     <= 1'b1;
            pend_mag_q <= sat_mag;
            pend_dir_q <= raw_dir;
        end else if (tick) begin
            pend_q <= 1'b0;
        end
    end

    // load the pulse on a tick and count it down tick by tick
    always_ff @(posedge clk) begin
        if (!rst_n || !run_en) begin
            remain_q <= '0;
            dir_q    <= DIR_NONE;
        end else if (tick) begin
            if (pend_q) begin
                remain_q <= pend_mag_q;
                dir_q    <= pend_dir_q;
            end else if (remain_q != '0) begin
                remain_q <= remain_q - 1'b1;
            end
        end
    end

    assign pulse_up = (remain_q != '0) && (dir_q == DIR_UP);
    assign pulse_dn = (remain_q != '0) && (dir_q == DIR_DN);
endmodule

// File: rtl/sd_lock_flag.sv
// Active-low lock flag: low when the captured count falls inside the
// window nominal +/- tolerance, refreshed only at a capture.
// Assumes: released (high) in reset and in the stopped state.
module sd_lock_flag #(
    parameter int CNT_W     = 10,
    parameter int NOMINAL   = 512,
    parameter int TOLERANCE = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_en,
    input  logic             cap_valid,
    input  logic [CNT_W-1:0] cap_count,
    output logic             lock_n
);
    localparam logic [CNT_W-1:0] LO_C = CNT_W'(NOMINAL - TOLERANCE);
    localparam logic [CNT_W-1:0] HI_C = CNT_W'(NOMINAL + TOLERANCE);

    logic in_window;

    // window comparison on the captured count
    assign in_window = (cap_count >= LO_C) && (cap_count <= HI_C);

    // flag register, refreshed at each capture
    always_ff @(posedge clk) begin
        if (!rst_n || !run_en) begin
            lock_n <= 1'b1;
        end else if (cap_valid) begin
            lock_n <= ~in_window;
        end
    end
endmodule

// File: rtl/speed_discrim.sv
// Crystal-referenced speed discriminator with lock detection.
// Prescaler -> tachometer edge detect -> period meter -> pulse generator
// and lock flag. Target tachometer frequency is clk / (PRESCALE*NOMINAL).
// Assumes: fg_in is a clean digital pulse; run_en is synchronous to clk.
module speed_discrim #(
    parameter int PRESCALE    = 16,
    parameter int NOMINAL     = 512,
    parameter int TOLERANCE   = 32,
    parameter int ERR_MAX     = 511,
    parameter int CNT_W       = 10,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run_en,
    input  logic fg_in,
    output logic ovr_up,
    output logic udr_dn,
    output logic pump_oe,
    output logic lock_n
);
    logic             tick;
    logic             fg_rise;
    logic             cap_valid;
    logic [CNT_W-1:0] cap_count;

    sd_prescaler #(.DIV(PRESCALE)) u_presc (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (tick)
    );

    sd_fg_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .fg_in   (fg_in),
        .fg_rise (fg_rise)
    );

    sd_period_meter #(.CNT_W(CNT_W)) u_meter (
        .clk       (clk),
        .rst_n     (rst_n),
        .run_en    (run_en),
        .tick      (tick),
        .fg_rise   (fg_rise),
        .cap_valid (cap_valid),
        .cap_count (cap_count)
    );

    sd_err_pulse #(
        .CNT_W   (CNT_W),
        .NOMINAL (NOMINAL),
        .ERR_MAX (ERR_MAX)
    ) u_pulse (
        .clk       (clk),
        .rst_n     (rst_n),
        .run_en    (run_en),
        .tick      (tick),
        .cap_valid (cap_valid),
        .cap_count (cap_count),
        .pulse_up  (ovr_up),
        .pulse_dn  (udr_dn)
    );

    sd_lock_flag #(
        .CNT_W     (CNT_W),
        .NOMINAL   (NOMINAL),
        .TOLERANCE (TOLERANCE)
    ) u_lock (
        .clk       (clk),
        .rst_n     (rst_n),
        .run_en    (run_en),
        .cap_valid (cap_valid),
        .cap_count (cap_count),
        .lock_n    (lock_n)
    );

    // the pump stage conducts whenever a correction is being driven
    assign pump_oe = ovr_up | udr_dn;
endmodule

// File: rtl/sd_checker.sv
// Port-level properties of the speed discriminator, bound to its top.
module sd_checker (
    input logic clk,
    input logic rst_n,
    input logic run_en,
    input logic ovr_up,
    input logic udr_dn,
    input logic pump_oe,
    input logic lock_n
);
    // R8
    pump_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pump_oe |-> (ovr_up ^ udr_dn));

    // R8
    pump_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !pump_oe |-> (!ovr_up && !udr_dn));

    // R9
    stop_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !run_en |=> (!pump_oe && lock_n));

    // R10
    reset_clear_chk: assert property (@(posedge clk)
        !rst_n |=> (lock_n && !ovr_up && !udr_dn));

    // R7
    lock_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(lock_n) |-> $past(run_en));
endmodule

bind speed_discrim sd_checker u_sd_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .run_en  (run_en),
    .ovr_up  (ovr_up),
    .udr_dn  (udr_dn),
    .pump_oe (pump_oe),
    .lock_n  (lock_n)
);

// File: tb/speed_discrim_bench.sv
// Scoreboard bench: the driver queues expected pulses, the monitor measures
// each pump pulse in clocks and compares it with the queue head.
module speed_discrim_bench;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic run_en = 1'b0;
    logic fg_in = 1'b0;
    logic ovr_up, udr_dn, pump_oe, lock_n;

    typedef struct {
        int    dir;   // 1 = up (overspeed), 2 = down (underspeed)
        int    cyc;   // expected width in reference clocks
        string tag;
    } exp_t;

    exp_t exp_q[$];
    int   n_vec = 0;
    int   n_bad = 0;
    int   cyc_cnt = 0;
    bit   mute = 1'b0;
    bit   done = 1'b0;
    int   up_run = 0;
    int   dn_run = 0;

    speed_discrim u_speed_discrim (
        .clk     (clk),
        .rst_n   (rst_n),
        .run_en  (run_en),
        .fg_in   (fg_in),
        .ovr_up  (ovr_up),
        .udr_dn  (udr_dn),
        .pump_oe (pump_oe),
        .lock_n  (lock_n)
    );

    always #5 clk = ~clk;

    task automatic check(input string tag, input int act, input int exp);
        n_vec++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: got %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic score(input int dir, input int width);
        exp_t e;
        n_vec++;
        if (exp_q.size() == 0) begin
            n_bad++;
            $display("FAIL R5: unexpected pulse dir=%0d width=%0d expected none", dir, width);
        end else begin
            e = exp_q.pop_front();
            if (e.dir != dir || e.cyc != width) begin
                n_bad++;
                $display("FAIL %s: pulse dir=%0d width=%0d expected dir=%0d width=%0d",
                         e.tag, dir, width, e.dir, e.cyc);
            end
        end
    endtask

    // monitor: measures pump pulses away from the active edge
    always @(negedge clk) begin
        if (!rst_n || mute) begin
            up_run = 0;
            dn_run = 0;
        end else begin
            if (ovr_up) up_run++;
            else if (up_run != 0) begin score(1, up_run); up_run = 0; end
            if (udr_dn) dn_run++;
            else if (dn_run != 0) begin score(2, dn_run); dn_run = 0; end
        end
    end

    // watchdog
    always @(posedge clk) begin
        cyc_cnt++;
        if (cyc_cnt > 190000 && !done) begin
            done = 1'b1;
            n_bad++;
            $display("FAIL watchdog: got %0d cycles expected completion", cyc_cnt);
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    // one tachometer period of n ticks, starting with a rising edge
    task automatic period(input int n);
        @(negedge clk) fg_in = 1'b1;
        repeat (3) @(negedge clk);
        fg_in = 1'b0;
        repeat (16 * n - 4) @(negedge clk);
    endtask

    // measure period of n ticks, then output period of l ticks
    task automatic pair(input int n, input int l, input string tag);
        int eff, w, d;
        exp_t e;
        eff = (n > 1023) ? 1023 : n;
        if (eff < 512)      begin w = 512 - eff; d = 1; end
        else if (eff > 512) begin w = eff - 512; d = 2; end
        else                begin w = 0; d = 0; end
        if (w > 511) w = 511;
        if (w > 0) begin
            e.dir = d; e.cyc = 16 * w; e.tag = tag;
            exp_q.push_back(e);
        end
        period(n);
        period(l);
        // R7: lock window 480..544 inclusive
        check({tag, "/R7 lock_n"}, int'(lock_n), (eff >= 480 && eff <= 544) ? 0 : 1);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        // R10: reset state
        check("R10 lock_n", int'(lock_n), 1);
        check("R10 pump_oe", int'(pump_oe), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R10 lock_n after release", int'(lock_n), 1);
        run_en = 1'b1;
        repeat (40) @(negedge clk);

        pair(512, 40, "R5");          // on target: no pulse, locked
        pair(480, 40, "R3");          // lower lock edge
        pair(479, 41, "R3");          // just outside below
        pair(544, 40, "R4");          // upper lock edge
        pair(545, 41, "R4");          // just outside above
        pair(300, 220, "R1");         // mid-range overspeed
        pair(1100, 520, "R6");        // counter saturation, slow motor
        pair(1, 520, "R6");           // near-zero period

        // stop in the middle of a pulse
        period(490);
        mute = 1'b1;
        @(negedge clk) fg_in = 1'b1;
        repeat (3) @(negedge clk);
        fg_in = 1'b0;
        repeat (60) @(negedge clk);
        check("R3 ovr_up mid pulse", int'(ovr_up), 1);
        check("R8 pump_oe mid pulse", int'(pump_oe), 1);
        check("R7 lock_n at 490", int'(lock_n), 0);
        run_en = 1'b0;
        @(negedge clk);
        check("R9 ovr_up stopped", int'(ovr_up), 0);
        check("R9 pump_oe stopped", int'(pump_oe), 0);
        check("R9 lock_n stopped", int'(lock_n), 1);
        for (int k = 0; k < 3; k++) period(50);
        check("R9 edges ignored pump_oe", int'(pump_oe), 0);
        check("R9 edges ignored lock_n", int'(lock_n), 1);

        // restart: the first edge must only arm
        mute = 1'b0;
        run_en = 1'b1;
        repeat (1600) @(negedge clk);
        check("R2 lock_n before edges", int'(lock_n), 1);
        pair(512, 40, "R2");

        repeat (400) @(negedge clk);
        check("R2 all expected pulses seen", exp_q.size(), 0);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule